// File: doc/BRIEF.md
# Register Write-Unlock Sequencer

This block guards the writable registers of a real-time-clock peripheral. It watches a simple memory-mapped write port of address, data and write enable. The rest of the peripheral may write its protected registers only after software has written seven fixed key bytes, each to its own word-aligned key address and in strict order. When the seventh key is accepted, the block raises a single unlock flag that gates those writes. Software must complete the series before it changes the debounce setting or releases the counter stop bit.

A mistake clears the progress back to the first step. A mistake is a wrong byte at the expected key address, or any write to a key address that is not the next one in the series. Writes that land outside the key window pass by without effect. The block also provides a read port. Each key register reads back as the last byte written to it, zero-extended. The progress count is available as an output.

Top module: `unlock_seq`

## Requirements
- R1: After reset, `unlocked_o` is 0, `progress_o` is 0 and every key register reads as 0.
- R2: Each key write goes to a 32-bit, word-aligned address, and only data bits 7:0 are compared. The accepted series, in order, is: 0xC6 at 0x04, 0x9A at 0x08, 0x59 at 0x0C, 0xA3 at 0x10, 0x57 at 0x14, 0x67 at 0x18, 0xD2 at 0x1C. Each accepted write raises `progress_o`, which counts the keys accepted so far, by one on the next clock edge.
- R3: While locked, a write of any other byte to the key address expected next sets `progress_o` to 0.
- R4: While locked, a write to any key address other than the one expected next sets `progress_o` to 0, whatever the byte.
- R5: A write to an address outside 0x04..0x1C, or to an address in that range that is not word-aligned, leaves `progress_o` unchanged. A cycle with no write also leaves it unchanged.
- R6: `unlocked_o` rises, and `progress_o` becomes 7, on the clock edge that accepts the seventh key.
- R7: Once set, `unlocked_o` stays at 1 until reset, and further key writes of any value leave `progress_o` at 7.
- R8: `rd_data_o` returns bits 7:0 of the last write to the key register at `rd_addr_i`, zero-extended, in the same cycle and regardless of lock state. It returns 0 for any non-key address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 32 | Key register readback, zero-extended |
| progress_o | output | 3 | Number of keys accepted (7 = unlocked) |
| unlocked_o | output | 1 | Unlock flag for protected writes |

## Verification
Every write is decoded and registered at the clock edge where the strobe is high. `progress_o`, `unlocked_o` and the key register contents therefore change one edge after the write is presented. `rd_data_o` follows `rd_addr_i` combinationally, with no extra delay. The bench applies each write across a single rising edge and samples at the falling edge that follows, so every result is read exactly one edge after its stimulus. The bench sweeps every pairing of current step and written key address. It also covers wrong bytes at every step, several out-of-window and misaligned addresses, and the full series followed by writes made after unlock.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;
  localparam int KEY_N  = 7;
  localparam int KEY_W  = 8;
  localparam int STEP_W = $clog2(KEY_N + 1);

  function automatic logic [KEY_W-1:0] key_value(input int unsigned idx);
    logic [KEY_W-1:0] v;
    case (idx)
      0: v = 8'hC6;
      1: v = 8'h9A;
      2: v = 8'h59;
      3: v = 8'hA3;
      4: v = 8'h57;
      5: v = 8'h67;
      6: v = 8'hD2;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/unlock_addr_dec.sv
module unlock_addr_dec
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [STEP_W-1:0] idx_o
);
  localparam logic [ADDR_W-1:0] BaseA = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] SpanA = ADDR_W'(KEY_N * 4);

  logic [ADDR_W-1:0] off;

  assign off   = addr_i - BaseA;
  assign hit_o = (addr_i[1:0] == 2'b00) && (addr_i >= BaseA) && (off < SpanA);
  assign idx_o = off[STEP_W+1:2];
endmodule

// File: rtl/unlock_key_bank.sv
module unlock_key_bank
  import unlock_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [STEP_W-1:0] widx_i,
  input  logic [KEY_W-1:0]  wbyte_i,
  input  logic              rhit_i,
  input  logic [STEP_W-1:0] ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [KEY_W-1:0] key_q [KEY_N];

  for (genvar g = 0; g < KEY_N; g++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    key_q[g] <= '0;
      else if (we_i && (widx_i == STEP_W'(g)))        key_q[g] <= wbyte_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < KEY_N; i++) begin
      if (rhit_i && (ridx_i == STEP_W'(i))) rdata_o = DATA_W'(key_q[i]);
    end
  end
endmodule

// File: rtl/unlock_tracker.sv
module unlock_tracker
  import unlock_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_we_i,
  input  logic [STEP_W-1:0] key_idx_i,
  input  logic [KEY_W-1:0]  key_byte_i,
  output logic [STEP_W-1:0] progress_o,
  output logic              unlocked_o
);
  localparam logic [STEP_W-1:0] Done = STEP_W'(KEY_N);

  logic [STEP_W-1:0] prog_q;
  logic              match;

  assign match = (key_idx_i == prog_q) &&
                 (key_byte_i == key_value(int'(prog_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_q <= '0;
    else if (key_we_i && (prog_q != Done)) begin
      // any miss, wrong byte or wrong slot, restarts the series
      prog_q <= match ? prog_q + 1'b1 : '0;
    end
  end

  assign progress_o = prog_q;
  assign unlocked_o = (prog_q == Done);
endmodule

// File: rtl/unlock_seq.sv
module unlock_seq
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BASE   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [STEP_W-1:0] progress_o,
  output logic              unlocked_o
);
  logic              w_hit, r_hit;
  logic [STEP_W-1:0] w_idx, r_idx;
  logic              key_we;

  unlock_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_wdec (
    .addr_i(wr_addr_i), .hit_o(w_hit), .idx_o(w_idx)
  );

  unlock_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_rdec (
    .addr_i(rd_addr_i), .hit_o(r_hit), .idx_o(r_idx)
  );

  assign key_we = wr_en_i && w_hit;

  unlock_key_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(key_we), .widx_i(w_idx), .wbyte_i(wr_data_i[KEY_W-1:0]),
    .rhit_i(r_hit), .ridx_i(r_idx), .rdata_o(rd_data_o)
  );

  unlock_tracker u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .key_we_i(key_we), .key_idx_i(w_idx), .key_byte_i(wr_data_i[KEY_W-1:0]),
    .progress_o(progress_o), .unlocked_o(unlocked_o)
  );
endmodule

// File: rtl/unlock_seq_chk.sv
module unlock_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int STEP_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [STEP_W-1:0] progress_o,
  input logic              unlocked_o
);
  // R7
  unlock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_o |=> unlocked_o && progress_o == 3'd7);

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(progress_o));

  // R6
  unlock_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(wr_en_i) && $past(progress_o) == 3'd6);

  // R2
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !unlocked_o) |=>
      (progress_o == '0) || $stable(progress_o) ||
      (progress_o == STEP_W'($past(progress_o) + 1'b1)));

  // R8
  read_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i ##1 $stable(rd_addr_i) |-> $stable(rd_data_o));
endmodule

bind unlock_seq unlock_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(3)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o), .progress_o(progress_o), .unlocked_o(unlocked_o)
);

// File: tb/unlock_seq_test.sv
module unlock_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  progress;
  logic        unlocked;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] keys [7] = '{8'hC6, 8'h9A, 8'h59, 8'hA3, 8'h57, 8'h67, 8'hD2};

  always #5 clk = ~clk;

  unlock_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .progress_o(progress), .unlocked_o(unlocked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // one write across one rising edge; returns at the following falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic advance(input int n);
    for (int i = 0; i < n; i++) wr(8'(4 + 4 * i), {24'hABCDEF, keys[i]});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 progress", 32'(progress), 0);
    chk("R1 unlocked", 32'(unlocked), 0);
    for (int k = 0; k < 7; k++) begin
      rd_addr = 8'(4 + 4 * k); #1;
      chk("R1 key readback", rd_data, 0);
    end

    // R2 R4 every step paired with every key address
    for (int s = 0; s < 7; s++) begin
      for (int k = 0; k < 7; k++) begin
        do_reset();
        advance(s);
        wr(8'(4 + 4 * k), 32'(keys[k]));
        if (k == s) chk("R2 in-order step", 32'(progress), 32'(s + 1));
        else        chk("R4 out-of-order restart", 32'(progress), 0);
      end
    end

    // R3 wrong byte at the expected address
    for (int s = 0; s < 7; s++) begin
      do_reset();
      advance(s);
      wr(8'(4 + 4 * s), 32'(keys[s] ^ 8'h10));
      chk("R3 wrong byte restart", 32'(progress), 0);
    end

    // R5 outside or misaligned addresses, and idle cycles
    do_reset();
    advance(3);
    wr(8'h00, 32'hC6); chk("R5 addr 0x00", 32'(progress), 3);
    wr(8'h20, 32'hA3); chk("R5 addr 0x20", 32'(progress), 3);
    wr(8'h12, 32'hA3); chk("R5 misaligned", 32'(progress), 3);
    wr(8'hFC, 32'h00); chk("R5 addr 0xFC", 32'(progress), 3);
    repeat (4) @(negedge clk);
    chk("R5 idle", 32'(progress), 3);
    wr(8'h10, 32'hA3); chk("R5 resumes", 32'(progress), 4);

    // R6 full series
    do_reset();
    advance(6);
    chk("R6 before last", 32'(unlocked), 0);
    wr(8'h1C, 32'hD2);
    chk("R6 unlocked", 32'(unlocked), 1);
    chk("R6 progress", 32'(progress), 7);

    // R7 sticky while writing wrong keys
    wr(8'h04, 32'h00);
    chk("R7 sticky flag", 32'(unlocked), 1);
    chk("R7 sticky progress", 32'(progress), 7);
    wr(8'h08, 32'h9A);
    chk("R7 rewrite ignored", 32'(progress), 7);

    // R8 readback after the writes above
    rd_addr = 8'h04; #1; chk("R8 last byte 0x04", rd_data, 32'h00);
    rd_addr = 8'h08; #1; chk("R8 last byte 0x08", rd_data, 32'h9A);
    rd_addr = 8'h1C; #1; chk("R8 last byte 0x1C", rd_data, 32'hD2);
    wr(8'h0C, 32'hFFFFFF5A);
    rd_addr = 8'h0C; #1; chk("R8 zero-extend", rd_data, 32'h5A);
    rd_addr = 8'h20; #1; chk("R8 non-key read", rd_data, 0);
    rd_addr = 8'h0D; #1; chk("R8 misaligned read", rd_data, 0);

    summary();
  end
endmodule